// File: doc/BRIEF.md
# Sample Clock Phase Tuner

This block finds a good sampling-clock phase for a high-speed card interface by sweeping eight candidate phases, indices 0 to 7, which stand for 0 to 315 degrees in 45-degree steps. For each candidate it drives the index out and pulses a clear of the interrupt status. It then asks an external requester to run one tuning transfer, and the requester answers pass or fail.

While it sweeps, the block records where the results turn from fail to pass (the rising point) and from pass to fail (the falling point). It stops early once both points are known. It then picks the index at the centre of the passing window, with a separate rule for a window that wraps from index 7 back to index 0. The tuning transfer, the phase shifter and the card protocol sit outside the block.

Top module: `tune_phase_ctrl`

## Requirements
- R1: After synchronous reset, done, error, trial_req and int_clr are 0 and final_idx is 0.
- R2: Each sweep tries phases in ascending order starting at 0. phase_idx holds the index under trial whenever trial_req is high, and trial_req is a one-cycle pulse.
- R3: int_clr is either all zeros or all ones. It is 17 bits wide, so all ones is 0x1FFFF. It is high for one cycle in the cycle before each trial_req and once more after the last trial result, so each sweep has one more clear pulse than it has trials.
- R4: At an index i greater than 0, a pass after a fail at i-1 sets the rising point to i, and a fail after a pass at i-1 sets the falling point to i-1. No edge is recorded at index 0.
- R5: The sweep ends after the trial in which both a rising and a falling point are known. Otherwise it ends after index 7.
- R6: If any trial passed, a missing rising point is taken as 0 and a missing falling point as 7.
- R7: When the falling point is not below the rising point, final_idx becomes (rise+fall)/2, rounded down.
- R8: When the falling point is below the rising point, final_idx becomes fall/2 if rise+fall exceeds 7, and (rise+7)/2 rounded down otherwise.
- R9: If no trial passed, error goes high together with done and final_idx keeps its previous value. error stays valid until the next accepted start.
- R10: A start while a sweep is in progress is ignored. The sweep continues without restarting at index 0.
- R11: done is a one-cycle pulse at the end of each sweep, and the rising and falling points are reset at each accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| int_clr | output | 17 | Interrupt status clear pulse, all ones when active |
| trial_req | output | 1 | Request one tuning transfer at phase_idx |
| phase_idx | output | 3 | Phase index under trial |
| trial_done | input | 1 | Tuning transfer finished (one cycle) |
| trial_pass | input | 1 | Result of the transfer, valid with trial_done |
| done | output | 1 | Sweep finished (one cycle) |
| error | output | 1 | No phase passed in the last sweep |
| final_idx | output | 3 | Chosen phase index |

## Verification
The assertions assume that trial_done arrives at most once per trial_req, no earlier than the cycle after the request, and never while the block is idle. The bench answers each request after a fixed latency of one or more cycles, and only for a request it has seen. Its model derives the trial count, the clear count and the chosen index from the pass pattern of each sweep. The patterns cover a plain window, wrapped windows on both sides of the sum rule, single-point windows, all-pass and all-fail, and a start pulsed in the middle of a sweep.

// File: rtl/tune_pkg.sv
package tune_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_END  = 2'd3
  } tune_state_e;
endpackage

// File: rtl/tune_edge_track.sv
module tune_edge_track #(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  input  logic             pass,
  output logic [IDX_W-1:0] rise,
  output logic             rise_vld,
  output logic [IDX_W-1:0] fall,
  output logic             fall_vld,
  output logic             any_pass,
  output logic             both_next
);
  logic prev_pass;
  logic set_rise, set_fall;

  // edges only exist between two tried indices (R4)
  always_comb begin
    set_rise  = upd && (idx != '0) && pass && !prev_pass;
    set_fall  = upd && (idx != '0) && !pass && prev_pass;
    both_next = (rise_vld || set_rise) && (fall_vld || set_fall);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rise      <= '0;
      rise_vld  <= 1'b0;
      fall      <= '0;
      fall_vld  <= 1'b0;
      any_pass  <= 1'b0;
      prev_pass <= 1'b0;
    end else if (upd) begin
      prev_pass <= pass;
      if (pass) any_pass <= 1'b1;
      if (set_rise) begin
        rise     <= idx;
        rise_vld <= 1'b1;
      end
      if (set_fall) begin
        fall     <= idx - IDX_W'(1);
        fall_vld <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tune_midpoint.sv
module tune_midpoint #(
  parameter int PHASES = 8,
  parameter int IDX_W  = 3
) (
  input  logic [IDX_W-1:0] rise,
  input  logic             rise_vld,
  input  logic [IDX_W-1:0] fall,
  input  logic             fall_vld,
  output logic [IDX_W-1:0] pick
);
  localparam int SUM_W = IDX_W + 1;
  localparam logic [SUM_W-1:0] TOP = SUM_W'(PHASES - 1);

  logic [SUM_W-1:0] r_eff, f_eff, sum_rf, sum_rt;

  always_comb begin
    // missing points fall back to the ends of the range (R6)
    r_eff  = rise_vld ? {1'b0, rise} : '0;
    f_eff  = fall_vld ? {1'b0, fall} : TOP;
    sum_rf = r_eff + f_eff;
    sum_rt = r_eff + TOP;
    if (f_eff >= r_eff)
      pick = IDX_W'(sum_rf >> 1);
    else if (sum_rf > TOP)
      pick = IDX_W'(f_eff >> 1);
    else
      pick = IDX_W'(sum_rt >> 1);
  end
endmodule

// File: rtl/tune_phase_ctrl.sv
module tune_phase_ctrl #(
  parameter int PHASES = 8,
  parameter int CLR_W  = 17,
  parameter int IDX_W  = $clog2(PHASES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [CLR_W-1:0] int_clr,
  output logic             trial_req,
  output logic [IDX_W-1:0] phase_idx,
  input  logic             trial_done,
  input  logic             trial_pass,
  output logic             done,
  output logic             error,
  output logic [IDX_W-1:0] final_idx
);
  import tune_pkg::*;

  localparam logic [CLR_W-1:0] CLR_ALL  = {CLR_W{1'b1}};
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PHASES - 1);

  tune_state_e      state;
  logic             accept, upd;
  logic [IDX_W-1:0] rise, fall, pick;
  logic             rise_vld, fall_vld, any_pass, both_next;

  assign accept = (state == ST_IDLE) && start;
  assign upd    = (state == ST_WAIT) && trial_done;

  tune_edge_track #(.IDX_W(IDX_W)) u_edges (
    .clk      (clk),
    .rst      (rst),
    .clr      (accept),
    .upd      (upd),
    .idx      (phase_idx),
    .pass     (trial_pass),
    .rise     (rise),
    .rise_vld (rise_vld),
    .fall     (fall),
    .fall_vld (fall_vld),
    .any_pass (any_pass),
    .both_next(both_next)
  );

  tune_midpoint #(.PHASES(PHASES), .IDX_W(IDX_W)) u_mid (
    .rise    (rise),
    .rise_vld(rise_vld),
    .fall    (fall),
    .fall_vld(fall_vld),
    .pick    (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase_idx <= '0;
      trial_req <= 1'b0;
      int_clr   <= '0;
      done      <= 1'b0;
      error     <= 1'b0;
      final_idx <= '0;
    end else begin
      done      <= 1'b0;
      trial_req <= 1'b0;
      int_clr   <= '0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            phase_idx <= '0;
            int_clr   <= CLR_ALL;
            error     <= 1'b0;
            state     <= ST_REQ;
          end
        end
        ST_REQ: begin
          trial_req <= 1'b1;
          state     <= ST_WAIT;
        end
        ST_WAIT: begin
          if (trial_done) begin
            int_clr <= CLR_ALL;
            if (both_next || (phase_idx == LAST_IDX)) begin
              state <= ST_END;
            end else begin
              phase_idx <= phase_idx + IDX_W'(1);
              state     <= ST_REQ;
            end
          end
        end
        ST_END: begin
          done  <= 1'b1;
          state <= ST_IDLE;
          if (any_pass) final_idx <= pick;
          else          error     <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tune_phase_sva.sv
module tune_phase_sva #(
  parameter int CLR_W = 17,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [CLR_W-1:0] int_clr,
  input logic             trial_req,
  input logic [IDX_W-1:0] phase_idx,
  input logic             done,
  input logic             error,
  input logic [IDX_W-1:0] final_idx
);
  a_r3_clr_mask: assert property (@(posedge clk) disable iff (rst)
    (int_clr == '0) || (int_clr == {CLR_W{1'b1}}));

  a_r3_clr_before_req: assert property (@(posedge clk) disable iff (rst)
    trial_req |-> $past(int_clr == {CLR_W{1'b1}}));

  a_r2_req_pulse: assert property (@(posedge clk) disable iff (rst)
    trial_req |=> !trial_req);

  a_r2_phase_held: assert property (@(posedge clk) disable iff (rst)
    trial_req |=> $stable(phase_idx));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_done_no_req: assert property (@(posedge clk) disable iff (rst)
    done |-> !trial_req);

  a_r9_error_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(error) |-> done);

  a_r9_final_kept_on_error: assert property (@(posedge clk) disable iff (rst)
    (done && error) |-> $stable(final_idx));
endmodule

bind tune_phase_ctrl tune_phase_sva #(.CLR_W(CLR_W), .IDX_W(IDX_W)) u_sva (
  .clk      (clk),
  .rst      (rst),
  .int_clr  (int_clr),
  .trial_req(trial_req),
  .phase_idx(phase_idx),
  .done     (done),
  .error    (error),
  .final_idx(final_idx)
);

// File: tb/tune_phase_ctrl_tb.sv
module tune_phase_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CLR_W = 17;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [CLR_W-1:0] int_clr;
  logic             trial_req;
  logic [2:0]       phase_idx;
  logic             trial_done = 1'b0;
  logic             trial_pass = 1'b0;
  logic             done;
  logic             error;
  logic [2:0]       final_idx;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;
  int  last_final = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tune_phase_ctrl u_dut (
    .clk(clk), .rst(rst), .start(start), .int_clr(int_clr),
    .trial_req(trial_req), .phase_idx(phase_idx),
    .trial_done(trial_done), .trial_pass(trial_pass),
    .done(done), .error(error), .final_idx(final_idx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural model of one sweep from its pass pattern
  task automatic model(input logic [7:0] p, output int ntr, output int pick,
                       output bit found);
    int  rise = -1;
    int  fall = -1;
    bit  prev = 1'b0;
    ntr = 0; found = 1'b0; pick = -1;
    for (int i = 0; i < 8; i++) begin
      ntr++;
      if (p[i]) found = 1'b1;
      if (i > 0) begin
        if (!p[i] && prev) fall = i - 1;
        if (p[i] && !prev) rise = i;
      end
      if (rise != -1 && fall != -1) break;
      prev = p[i];
    end
    if (found) begin
      if (rise == -1) rise = 0;
      if (fall == -1) fall = 7;
      if (fall >= rise)          pick = (rise + fall) / 2;
      else if (rise + fall > 7)  pick = fall / 2;
      else                       pick = (rise + 7) / 2;
    end
  endtask

  task automatic sweep(input logic [7:0] p, input int lat, input bit poke,
                       input string tag);
    int ntr, pick, trials, clrs;
    bit found, got_done, waited;
    model(p, ntr, pick, found);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    trials = 0; clrs = 0; got_done = 1'b0;
    for (int cyc = 0; cyc < 300 && !got_done; cyc++) begin
      waited = 1'b0;
      if (int_clr == {CLR_W{1'b1}}) clrs++;
      else chk(int_clr == '0, {tag, " R3 clr value"}, int'(int_clr), 0);
      if (trial_req) begin
        chk(int'(phase_idx) == trials, {tag, " R2 phase order"}, phase_idx, trials);
        trials++;
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (poke) start = 1'b1;   // R10: start while busy
        end
        start = 1'b0;
        trial_done = 1'b1;
        trial_pass = p[phase_idx];
        @(negedge clk);
        trial_done = 1'b0;
        trial_pass = 1'b0;
        waited = 1'b1;
      end else if (done) begin
        got_done = 1'b1;
        chk(trials == ntr, {tag, " R5 trial count"}, trials, ntr);
        chk(clrs == ntr + 1, {tag, " R3 clear count"}, clrs, ntr + 1);
        chk(error == !found, {tag, " R9 error flag"}, error, !found);
        if (found) begin
          chk(int'(final_idx) == pick, {tag, " R7 R8 R6 chosen index"}, final_idx, pick);
          last_final = pick;
        end else begin
          chk(int'(final_idx) == last_final, {tag, " R9 index kept"}, final_idx, last_final);
        end
      end
      if (!waited) @(negedge clk);
    end
    chk(got_done, {tag, " R11 done seen"}, got_done, 1);
    chk(!done, {tag, " R11 done one cycle"}, done, 0);
    chk(error == !found, {tag, " R9 error held"}, error, !found);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!done && !error && !trial_req, "R1 reset flags", {done, error, trial_req}, 0);
    chk(int_clr == '0, "R1 reset clear", int'(int_clr), 0);
    chk(final_idx == 3'd0, "R1 reset index", final_idx, 0);

    sweep(8'b0011_1100, 1, 1'b0, "plain window R4 R7");
    sweep(8'hFF,        2, 1'b0, "all pass R6");
    sweep(8'b1100_0011, 1, 1'b0, "wrap low sum R8");
    sweep(8'h00,        1, 1'b0, "no pass R9");
    sweep(8'b1101_1111, 3, 1'b0, "wrap high sum R8");
    sweep(8'h80,        1, 1'b0, "pass at last R6");
    sweep(8'h01,        1, 1'b0, "pass at first R4");
    sweep(8'hF8,        2, 1'b0, "open top R6");
    sweep(8'b0001_1000, 3, 1'b1, "busy start R10 R11");
    sweep(8'h00,        1, 1'b0, "second no pass R9");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end
endmodule